// File: doc/BRIEF.md
# CAN Operating Mode Controller

This block is the mode sequencer of a CAN protocol controller. It decides whether the controller is in initialization, normal, sleep or bus-off operation. It also decides when to move between them. Software supplies level requests: enter initialization, enter sleep, allow automatic wake-up and allow automatic bus-off recovery. The bit-stream engine supplies a once-per-bit tick, the sampled receive level, a flag saying a frame is being sent or received, and a one-clock bus-off entry event.

A requested mode change never cuts a frame short. The controller waits until the frame flag is low. To rejoin the bus, it counts consecutive recessive bits: one run of 11 ends initialization or a wake-up. Recovery from bus-off needs 128 completed runs. While asleep, the controller can wake by itself on a start-of-frame edge. It then pulses a clear for the external sleep request bit. The protocol engine is enabled only in normal mode.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, init_ack is 1, sleep_ack is 0, engine_en is 0 and sleep_clr is 0.
- R2: In normal mode, a high req_init takes effect at the first bit tick with frame_busy low. From the next clock, init_ack is 1 and engine_en is 0. While frame_busy is high, init_ack stays 0.
- R3: With req_init and req_sleep low in initialization, the 11th consecutive tick with rx_bit=1 (recessive) clears init_ack and sets engine_en on the following clock. After 10 such ticks, the mode is unchanged.
- R4: In normal mode, a high req_sleep takes effect at the first bit tick with frame_busy low. sleep_ack then becomes 1 and engine_en becomes 0.
- R5: In sleep, a tick with req_sleep low clears sleep_ack. Normal mode follows after 11 further consecutive recessive ticks.
- R6: In sleep with auto_wake=1, a tick with rx_bit=0 that follows a tick with rx_bit=1 produces a one-clock sleep_clr pulse and clears sleep_ack. With auto_wake=0, the same pattern leaves sleep_ack at 1 and gives no pulse.
- R7: A busoff_evt pulse in normal mode drives init_ack, sleep_ack and engine_en all to 0 on the next clock.
- R8: In bus-off with auto_busoff=1, normal mode resumes after the 128th completed run of 11 recessive ticks. A dominant tick discards only the partial run in progress.
- R9: In bus-off with auto_busoff=0, recessive ticks have no effect. A tick with req_init high moves the controller to initialization (init_ack=1).
- R10: When req_init and req_sleep are both high at a tick in normal mode, initialization is entered and sleep is not.
- R11: A dominant tick restarts the count of consecutive recessive bits needed to leave initialization.
- R12: At most one of init_ack, sleep_ack and engine_en is high at any time. None of them changes on a clock without a bit tick, except on bus-off entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock strobe, once per bit time |
| rx_bit | input | 1 | Sampled receive level (1 = recessive) |
| frame_busy | input | 1 | A frame is being sent or received |
| busoff_evt | input | 1 | One-clock pulse: error logic entered bus-off |
| req_init | input | 1 | Software initialization request |
| req_sleep | input | 1 | Software sleep request |
| auto_wake | input | 1 | Enable wake-up on start-of-frame |
| auto_busoff | input | 1 | Enable automatic bus-off recovery |
| init_ack | output | 1 | Initialization mode active |
| sleep_ack | output | 1 | Sleep mode active |
| sleep_clr | output | 1 | One-clock pulse clearing the sleep request |
| engine_en | output | 1 | Protocol engine enable (normal mode) |

## Verification
A wrong mode state shows up at the three mode flags on the clock after the bit tick that caused it. The recessive-run counters are hidden. An error in them appears only as a mode exit on the wrong tick: one tick early or late for the 11-bit run, or up to a whole run off for the 128-run recovery. The bench therefore checks the flags on the tick before each expected exit and again on the exit tick. It also places dominant bits inside partial runs to show which counter they reset.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [2:0] {
    MD_INIT   = 3'd0,
    MD_NORMAL = 3'd1,
    MD_SLEEP  = 3'd2,
    MD_SYNC   = 3'd3,
    MD_BUSOFF = 3'd4
  } mode_t;
endpackage

// File: rtl/can_recessive_runs.sv
// Counts consecutive recessive bits and completed runs of them.
module can_recessive_runs #(
  parameter int RUN_LEN = 11,
  parameter int RUN_NUM = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx,
  input  logic count_en,
  output logic run_done,
  output logic runs_done
);
  localparam int RW = $clog2(RUN_LEN);
  localparam int NW = (RUN_NUM > 1) ? $clog2(RUN_NUM) : 1;
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);
  localparam logic [NW-1:0] NUM_LAST = NW'(RUN_NUM - 1);

  logic [RW-1:0] bit_cnt;
  logic [NW-1:0] run_cnt;

  assign run_done  = tick && count_en && rx && (bit_cnt == RUN_LAST);
  assign runs_done = run_done && (run_cnt == NUM_LAST);

  always_ff @(posedge clk) begin
    if (rst || !count_en) begin
      bit_cnt <= '0;
      run_cnt <= '0;
    end else if (tick) begin
      if (!rx) begin
        bit_cnt <= '0;
      end else if (bit_cnt == RUN_LAST) begin
        bit_cnt <= '0;
        run_cnt <= (run_cnt == NUM_LAST) ? '0 : run_cnt + 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_mode_fsm.sv
// Mode state machine with registered mode flags.
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic frame_busy,
  input  logic busoff_evt,
  input  logic req_init,
  input  logic req_sleep,
  input  logic auto_wake,
  input  logic auto_busoff,
  input  logic run_done,
  input  logic runs_done,
  output logic count_en,
  output logic init_ack,
  output logic sleep_ack,
  output logic sleep_clr,
  output logic engine_en
);
  mode_t state, nxt;
  logic  rx_prev;
  logic  sof_edge;
  logic  wake_hw;

  assign sof_edge = bit_tick && rx_prev && !rx_bit;

  always_comb begin
    unique case (state)
      MD_INIT:   count_en = !req_init && !req_sleep;
      MD_SYNC:   count_en = !req_init && !req_sleep;
      MD_BUSOFF: count_en = auto_busoff && !req_init;
      default:   count_en = 1'b0;
    endcase
  end

  always_comb begin
    nxt     = state;
    wake_hw = 1'b0;
    unique case (state)
      MD_NORMAL: begin
        if (busoff_evt)                             nxt = MD_BUSOFF;
        else if (bit_tick && !frame_busy && req_init)  nxt = MD_INIT;
        else if (bit_tick && !frame_busy && req_sleep) nxt = MD_SLEEP;
      end
      MD_INIT: begin
        if (bit_tick && !req_init) begin
          if (req_sleep)     nxt = MD_SLEEP;
          else if (run_done) nxt = MD_NORMAL;
        end
      end
      MD_SLEEP: begin
        if (bit_tick) begin
          if (req_init)       nxt = MD_INIT;
          else if (!req_sleep) nxt = MD_SYNC;
          else if (auto_wake && sof_edge) begin
            nxt     = MD_SYNC;
            wake_hw = 1'b1;
          end
        end
      end
      MD_SYNC: begin
        if (bit_tick) begin
          if (req_init)       nxt = MD_INIT;
          else if (req_sleep) nxt = MD_SLEEP;
          else if (run_done)  nxt = MD_NORMAL;
        end
      end
      MD_BUSOFF: begin
        if (bit_tick) begin
          if (req_init)                      nxt = MD_INIT;
          else if (auto_busoff && runs_done) nxt = MD_NORMAL;
        end
      end
      default: nxt = MD_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MD_INIT;
      rx_prev   <= 1'b1;
      init_ack  <= 1'b1;
      sleep_ack <= 1'b0;
      engine_en <= 1'b0;
      sleep_clr <= 1'b0;
    end else begin
      state     <= nxt;
      if (bit_tick) rx_prev <= rx_bit;
      init_ack  <= (nxt == MD_INIT);
      sleep_ack <= (nxt == MD_SLEEP);
      engine_en <= (nxt == MD_NORMAL);
      sleep_clr <= wake_hw;
    end
  end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl #(
  parameter int RUN_LEN = 11,
  parameter int RUN_NUM = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic frame_busy,
  input  logic busoff_evt,
  input  logic req_init,
  input  logic req_sleep,
  input  logic auto_wake,
  input  logic auto_busoff,
  output logic init_ack,
  output logic sleep_ack,
  output logic sleep_clr,
  output logic engine_en
);
  logic count_en, run_done, runs_done;

  can_recessive_runs #(.RUN_LEN(RUN_LEN), .RUN_NUM(RUN_NUM)) u_runs (
    .clk(clk), .rst(rst), .tick(bit_tick), .rx(rx_bit), .count_en(count_en),
    .run_done(run_done), .runs_done(runs_done)
  );

  can_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .frame_busy(frame_busy), .busoff_evt(busoff_evt), .req_init(req_init),
    .req_sleep(req_sleep), .auto_wake(auto_wake), .auto_busoff(auto_busoff),
    .run_done(run_done), .runs_done(runs_done), .count_en(count_en),
    .init_ack(init_ack), .sleep_ack(sleep_ack), .sleep_clr(sleep_clr),
    .engine_en(engine_en)
  );
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic frame_busy,
  input logic busoff_evt,
  input logic req_init,
  input logic auto_wake,
  input logic init_ack,
  input logic sleep_ack,
  input logic sleep_clr,
  input logic engine_en
);
  AST_INIT_WAITS_FRAME: assert property (@(posedge clk) disable iff (rst)
    engine_en && frame_busy |=> !init_ack); // R2
  AST_INIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(init_ack) |-> $past(req_init)); // R2
  AST_NORMAL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(engine_en) |-> $past(bit_tick)); // R3
  AST_SLEEP_WAITS_FRAME: assert property (@(posedge clk) disable iff (rst)
    engine_en && frame_busy |=> !sleep_ack); // R4
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
    sleep_clr |-> !sleep_ack && $past(sleep_ack) && $past(auto_wake)); // R6
  AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (rst)
    engine_en && busoff_evt |=> !init_ack && !sleep_ack && !engine_en); // R7
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $countones({init_ack, sleep_ack, engine_en}) <= 1); // R12
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !bit_tick && !busoff_evt |=> $stable(init_ack) && $stable(sleep_ack) && $stable(engine_en)); // R12
endmodule

bind can_mode_ctrl can_mode_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .frame_busy(frame_busy),
  .busoff_evt(busoff_evt), .req_init(req_init), .auto_wake(auto_wake),
  .init_ack(init_ack), .sleep_ack(sleep_ack), .sleep_clr(sleep_clr),
  .engine_en(engine_en)
);

// File: tb/tb_can_mode_ctrl.sv
module tb_can_mode_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0, rx_bit = 1'b1, frame_busy = 1'b0, busoff_evt = 1'b0;
  logic req_init = 1'b1, req_sleep = 1'b0, auto_wake = 1'b0, auto_busoff = 1'b0;
  logic init_ack, sleep_ack, sleep_clr, engine_en;
  int   n_checks = 0, n_errors = 0, cyc = 0;
  logic clr_seen = 1'b0;

  always #5 clk = ~clk;

  can_mode_ctrl dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .frame_busy(frame_busy), .busoff_evt(busoff_evt), .req_init(req_init),
    .req_sleep(req_sleep), .auto_wake(auto_wake), .auto_busoff(auto_busoff),
    .init_ack(init_ack), .sleep_ack(sleep_ack), .sleep_clr(sleep_clr),
    .engine_en(engine_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_errors = n_errors + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  // flags as {init_ack, sleep_ack, engine_en}
  task automatic check_flags(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {init_ack, sleep_ack, engine_en};
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_errors = n_errors + 1;
      $display("FAIL %s: flags actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_errors = n_errors + 1;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one bit time: tick with given level, then three idle clocks
  task automatic send_bit(input logic v);
    @(negedge clk);
    rx_bit = v;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    if (sleep_clr) begin
      clr_seen = 1'b1;
      req_sleep = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(input logic v, input int n);
    for (int i = 0; i < n; i++) send_bit(v);
  endtask

  task automatic pulse_busoff();
    @(negedge clk);
    busoff_evt = 1'b1;
    @(negedge clk);
    busoff_evt = 1'b0;
  endtask

  task automatic go_normal();
    req_init = 1'b0;
    req_sleep = 1'b0;
    send_bits(1'b1, 11);
  endtask

  task automatic t_reset();
    check_flags("R1 reset flags", 3'b100);
    check_bit("R1 reset sleep_clr", sleep_clr, 1'b0);
  endtask

  task automatic t_init_exit();
    req_init = 1'b0;
    send_bits(1'b1, 10);
    check_flags("R3 after 10 recessive", 3'b100);
    send_bit(1'b1);
    check_flags("R3 after 11 recessive", 3'b001);
  endtask

  task automatic t_init_request();
    frame_busy = 1'b1;
    req_init = 1'b1;
    send_bits(1'b1, 3);
    check_flags("R2 held by frame", 3'b001);
    frame_busy = 1'b0;
    send_bit(1'b1);
    check_flags("R2 init entered", 3'b100);
  endtask

  task automatic t_dominant_restart();
    req_init = 1'b0;
    send_bits(1'b1, 7);
    send_bit(1'b0);
    send_bits(1'b1, 10);
    check_flags("R11 run restarted", 3'b100);
    send_bit(1'b1);
    check_flags("R11 full run done", 3'b001);
  endtask

  task automatic t_sleep_enter();
    frame_busy = 1'b1;
    req_sleep = 1'b1;
    send_bits(1'b1, 3);
    check_flags("R4 held by frame", 3'b001);
    frame_busy = 1'b0;
    send_bit(1'b1);
    check_flags("R4 sleep entered", 3'b010);
  endtask

  task automatic t_sw_wake();
    req_sleep = 1'b0;
    send_bit(1'b1);
    check_flags("R5 sleep left", 3'b000);
    send_bits(1'b1, 10);
    check_flags("R5 still syncing", 3'b000);
    send_bit(1'b1);
    check_flags("R5 normal", 3'b001);
  endtask

  task automatic t_auto_wake();
    auto_wake = 1'b0;
    req_sleep = 1'b1;
    clr_seen = 1'b0;
    send_bit(1'b1);
    check_flags("R6 asleep", 3'b010);
    send_bit(1'b1);
    send_bit(1'b0);
    check_flags("R6 edge ignored when disabled", 3'b010);
    check_bit("R6 no clear pulse", clr_seen, 1'b0);
    auto_wake = 1'b1;
    send_bit(1'b1);
    send_bit(1'b0);
    check_flags("R6 woken by edge", 3'b000);
    check_bit("R6 clear pulse", clr_seen, 1'b1);
    auto_wake = 1'b0;
    send_bits(1'b1, 11);
    check_flags("R6 normal after wake", 3'b001);
  endtask

  task automatic t_priority();
    req_init = 1'b1;
    req_sleep = 1'b1;
    send_bit(1'b1);
    check_flags("R10 init wins", 3'b100);
    go_normal();
    check_flags("R10 back to normal", 3'b001);
  endtask

  task automatic t_busoff_auto();
    auto_busoff = 1'b1;
    pulse_busoff();
    check_flags("R7 bus-off entered", 3'b000);
    send_bits(1'b1, 5);
    send_bit(1'b0);
    send_bits(1'b1, 128 * 11 - 1);
    check_flags("R8 one bit short", 3'b000);
    send_bit(1'b1);
    check_flags("R8 recovered", 3'b001);
  endtask

  task automatic t_busoff_manual();
    auto_busoff = 1'b0;
    pulse_busoff();
    check_flags("R7 bus-off again", 3'b000);
    send_bits(1'b1, 1500);
    check_flags("R9 no auto recovery", 3'b000);
    req_init = 1'b1;
    send_bit(1'b1);
    check_flags("R9 software exit", 3'b100);
    req_init = 1'b0;
    repeat (8) @(negedge clk);
    check_flags("R12 no change without tick", 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_init_exit();
    t_init_request();
    t_dominant_restart();
    t_sleep_enter();
    t_sw_wake();
    t_auto_wake();
    t_priority();
    t_busoff_auto();
    t_busoff_manual();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule